// File: doc/BRIEF.md
# Character-cell VGA text generator

This block paints a fixed 80-column by 24-row colour text screen onto a 640x480 VGA raster. It runs from one pixel clock (25.175 MHz in the target system) and has only one mode, with no configuration registers. As the raster moves, the block reads one 16-bit cell word per character position from an external display memory that has a registered read port. It turns that word into an address for an external glyph ROM, which also has a registered read port. It then shifts the returned 8-pixel row out one pixel per clock. For each pixel, the block selects either the cell's foreground colour or its background colour.

Each glyph has 32 row slots, and the block addresses only the first 20 of them. Blinking costs no pixel logic. A per-cell flash bit is ANDed with a slow frame-rate toggle, and the result drives the ROM's invert-bank address line. A block-graphics bit in the cell selects a second glyph bank in the same way. Horizontal sync, vertical sync and the colour outputs all leave the block three clocks after the raster position that produced them. That delay covers the memory read, the ROM read and the serializer load.

Top module: `vga_text_engine`

## Requirements
- R1: A line lasts 800 clocks: 640 visible, then 16 front porch, 96 sync and 48 back porch. `hsync_n` is low for exactly the 96 sync clocks, which start 656 clocks after the line's first visible pixel at the port.
- R2: A frame lasts 525 lines: 480 visible, then 10 front porch, 2 sync and 33 back porch. `vsync_n` is low throughout lines 490 and 491, counting from 0.
- R3: Let raster position k be the number of clocks since `rst_n` was released. The ports show position k-3. While reset is low, and for the first three clocks after release, `rgb` is 0 and both syncs are high.
- R4: During the clock in which the raster reaches the first pixel of a visible cell, `vram_addr` equals char_row*80 + column. The memory is expected to return that word one clock later.
- R5: On the clock after the memory fetch, `rom_addr` carries: bit 14 block select, bit 13 invert select, bits 12:5 the character code, and bits 4:0 the scan line within the character row (0 to 19). ROM data is expected one clock later.
- R6: The invert select equals cell bit 9 (flash) ANDed with `blink`. The block select equals cell bit 8.
- R7: The cell word holds the code in bits 7:0, foreground RGB in bits 12:10 and background RGB in bits 15:13. The glyph byte's MSB is the leftmost pixel. A 1 pixel outputs the foreground colour and a 0 pixel the background colour. Within `rgb`, bit 2 is red, bit 1 green and bit 0 blue.
- R8: `rgb` is 0 for every position outside the visible 640x480 region.
- R9: `blink` is 0 after reset. It inverts after every 32nd completed frame and changes only at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vram_addr | output | 11 | Cell index presented to the display memory |
| vram_data | input | 16 | Cell word returned one clock after the address |
| rom_addr | output | 15 | Glyph ROM address |
| rom_data | input | 8 | Glyph row returned one clock after the address |
| rgb | output | 3 | Pixel colour, red in bit 2 |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blink | output | 1 | Slow flash toggle |

## Verification
The assertions assume that both memories answer exactly one clock after an address is presented. They also assume that the fetch for a cell never falls in the last clock of a frame, so `blink` cannot change between a fetch and the ROM address it produces. The bench models the display memory and the ROM as registered lookups driven on the clock edge, which meets the one-clock rule. Their contents are deterministic hash functions, so flash, block, code and colour bits all vary across cells. The bench runs a reduced-geometry instance for twelve frames, long enough to see `blink` take both values, and a default-geometry instance for the first dozen lines.

// File: rtl/vga_text_pkg.sv
package vga_text_pkg;

  // Cell word, MSB first: background, foreground, flash, block, code
  typedef struct packed {
    logic [2:0] bg;
    logic [2:0] fg;
    logic       flash;
    logic       block;
    logic [7:0] code;
  } cell_t;

  localparam int CELL_W     = 8;   // pixels per character
  localparam int ROW_W      = 5;   // glyph row field width (32 slots)
  localparam int GADDR_W    = 15;  // glyph ROM address width
  localparam int PIPE_DEPTH = 3;   // raster-to-port latency

  // Glyph ROM address: block bank, invert bank, code, scan row
  function automatic logic [GADDR_W-1:0] glyph_addr(cell_t c, logic [ROW_W-1:0] row,
                                                    logic blink_on);
    return {c.block, c.flash & blink_on, c.code, row};
  endfunction

  // Colour selection for one pixel
  function automatic logic [2:0] pixel_rgb(logic pix, logic [2:0] fg, logic [2:0] bg,
                                           logic vis);
    if (!vis) return 3'b000;
    return pix ? fg : bg;
  endfunction

  // Half-open interval test [lo, hi)
  function automatic logic in_span(logic [15:0] pos, logic [15:0] lo, logic [15:0] hi);
    return (pos >= lo) && (pos < hi);
  endfunction

endpackage

// File: rtl/vga_text_timing.sv
module vga_text_timing
  import vga_text_pkg::*;
#(
  parameter int COLS         = 80,
  parameter int GLYPH_H      = 20,
  parameter int H_VIS        = 640,
  parameter int H_FP         = 16,
  parameter int H_SYNC       = 96,
  parameter int H_BP         = 48,
  parameter int V_VIS        = 480,
  parameter int V_FP         = 10,
  parameter int V_SYNC       = 2,
  parameter int V_BP         = 33,
  parameter int BLINK_FRAMES = 32,
  parameter int ADDR_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetch_stb,
  output logic [ADDR_W-1:0] cell_addr,
  output logic [ROW_W-1:0]  scan_row,
  output logic              visible,
  output logic              hsync_raw,
  output logic              vsync_raw,
  output logic              frame_end,
  output logic              blink
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int FW      = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

  logic [HW-1:0]     hcnt;
  logic [VW-1:0]     vcnt;
  logic [ADDR_W-1:0] row_base;
  logic [FW-1:0]     fcnt;
  logic              line_end;
  logic              h_vis;
  logic              v_vis;

  assign line_end  = (hcnt == HW'(H_TOTAL - 1));
  assign frame_end = line_end && (vcnt == VW'(V_TOTAL - 1));
  assign h_vis     = (hcnt < HW'(H_VIS));
  assign v_vis     = (vcnt < VW'(V_VIS));
  assign visible   = h_vis && v_vis;
  assign fetch_stb = visible && (hcnt[2:0] == 3'd0);
  assign cell_addr = row_base + ADDR_W'(hcnt >> 3);
  assign hsync_raw = in_span(16'(hcnt), 16'(H_VIS + H_FP), 16'(H_VIS + H_FP + H_SYNC));
  assign vsync_raw = in_span(16'(vcnt), 16'(V_VIS + V_FP), 16'(V_VIS + V_FP + V_SYNC));

  // Raster counters and character-row tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt     <= '0;
      vcnt     <= '0;
      scan_row <= '0;
      row_base <= '0;
    end else begin
      if (line_end) hcnt <= '0;
      else          hcnt <= hcnt + 1'b1;

      if (frame_end) begin
        vcnt     <= '0;
        scan_row <= '0;
        row_base <= '0;
      end else if (line_end) begin
        vcnt <= vcnt + 1'b1;
        if (v_vis) begin
          if (scan_row == ROW_W'(GLYPH_H - 1)) begin
            scan_row <= '0;
            row_base <= row_base + ADDR_W'(COLS);
          end else begin
            scan_row <= scan_row + 1'b1;
          end
        end
      end
    end
  end

  // Frame divider for the flash toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt  <= '0;
      blink <= 1'b0;
    end else if (frame_end) begin
      if (fcnt == FW'(BLINK_FRAMES - 1)) begin
        fcnt  <= '0;
        blink <= ~blink;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vga_text_fetch.sv
module vga_text_fetch
  import vga_text_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_stb,
  input  logic [ROW_W-1:0]   scan_row,
  input  logic               blink,
  input  logic [15:0]        vram_data,
  output logic [GADDR_W-1:0] rom_addr,
  output logic               load_stb,
  output logic [2:0]         fg_pend,
  output logic [2:0]         bg_pend
);
  cell_t            word;
  logic             fetch_d1;
  logic             fetch_d2;
  logic [ROW_W-1:0] row_d1;

  assign word     = cell_t'(vram_data);
  assign rom_addr = glyph_addr(word, row_d1, blink);
  assign load_stb = fetch_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_d1 <= 1'b0;
      fetch_d2 <= 1'b0;
      row_d1   <= '0;
      fg_pend  <= '0;
      bg_pend  <= '0;
    end else begin
      fetch_d1 <= fetch_stb;
      fetch_d2 <= fetch_d1;
      row_d1   <= scan_row;
      if (fetch_d1) begin
        fg_pend <= word.fg;
        bg_pend <= word.bg;
      end
    end
  end

endmodule

// File: rtl/vga_text_shifter.sv
module vga_text_shifter
  import vga_text_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_stb,
  input  logic [7:0]  rom_data,
  input  logic [2:0]  fg_pend,
  input  logic [2:0]  bg_pend,
  input  logic        visible,
  input  logic        hsync_raw,
  input  logic        vsync_raw,
  output logic [2:0]  rgb,
  output logic        hsync_n,
  output logic        vsync_n
);
  logic [CELL_W-1:0]     shreg;
  logic [2:0]            fg_q;
  logic [2:0]            bg_q;
  logic [PIPE_DEPTH-1:0] vis_pipe;
  logic [PIPE_DEPTH-1:0] hs_pipe;
  logic [PIPE_DEPTH-1:0] vs_pipe;

  // Serializer and colour latch load together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      fg_q  <= '0;
      bg_q  <= '0;
    end else if (load_stb) begin
      shreg <= rom_data;
      fg_q  <= fg_pend;
      bg_q  <= bg_pend;
    end else begin
      shreg <= {shreg[CELL_W-2:0], 1'b0};
    end
  end

  // Blanking and sync delay lines matched to the pixel path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_pipe <= '0;
      hs_pipe  <= '0;
      vs_pipe  <= '0;
    end else begin
      vis_pipe <= {vis_pipe[PIPE_DEPTH-2:0], visible};
      hs_pipe  <= {hs_pipe[PIPE_DEPTH-2:0], hsync_raw};
      vs_pipe  <= {vs_pipe[PIPE_DEPTH-2:0], vsync_raw};
    end
  end

  assign rgb     = pixel_rgb(shreg[CELL_W-1], fg_q, bg_q, vis_pipe[PIPE_DEPTH-1]);
  assign hsync_n = ~hs_pipe[PIPE_DEPTH-1];
  assign vsync_n = ~vs_pipe[PIPE_DEPTH-1];

endmodule

// File: rtl/vga_text_engine.sv
module vga_text_engine
  import vga_text_pkg::*;
#(
  parameter int COLS         = 80,
  parameter int ROWS         = 24,
  parameter int GLYPH_H      = 20,
  parameter int H_FP         = 16,
  parameter int H_SYNC       = 96,
  parameter int H_BP         = 48,
  parameter int V_FP         = 10,
  parameter int V_SYNC       = 2,
  parameter int V_BP         = 33,
  parameter int BLINK_FRAMES = 32,
  localparam int ADDR_W      = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] vram_addr,
  input  logic [15:0]       vram_data,
  output logic [14:0]       rom_addr,
  input  logic [7:0]        rom_data,
  output logic [2:0]        rgb,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blink
);
  localparam int H_VIS = COLS * CELL_W;
  localparam int V_VIS = ROWS * GLYPH_H;

  // Internal events, named for the checker
  logic             fetch_stb;
  logic             load_stb;
  logic             visible;
  logic             hsync_raw;
  logic             vsync_raw;
  logic             frame_end;
  logic [ROW_W-1:0] scan_row;
  logic [2:0]       fg_pend;
  logic [2:0]       bg_pend;

  vga_text_timing #(
    .COLS(COLS), .GLYPH_H(GLYPH_H),
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .BLINK_FRAMES(BLINK_FRAMES), .ADDR_W(ADDR_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n),
    .fetch_stb(fetch_stb), .cell_addr(vram_addr), .scan_row(scan_row),
    .visible(visible), .hsync_raw(hsync_raw), .vsync_raw(vsync_raw),
    .frame_end(frame_end), .blink(blink)
  );

  vga_text_fetch u_fetch (
    .clk(clk), .rst_n(rst_n),
    .fetch_stb(fetch_stb), .scan_row(scan_row), .blink(blink),
    .vram_data(vram_data), .rom_addr(rom_addr), .load_stb(load_stb),
    .fg_pend(fg_pend), .bg_pend(bg_pend)
  );

  vga_text_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_stb(load_stb), .rom_data(rom_data),
    .fg_pend(fg_pend), .bg_pend(bg_pend),
    .visible(visible), .hsync_raw(hsync_raw), .vsync_raw(vsync_raw),
    .rgb(rgb), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

endmodule

// File: rtl/vga_text_engine_chk.sv
module vga_text_engine_chk #(
  parameter int COLS    = 80,
  parameter int ROWS    = 24,
  parameter int GLYPH_H = 20,
  parameter int ADDR_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_stb,
  input logic              load_stb,
  input logic              visible,
  input logic              hsync_raw,
  input logic              frame_end,
  input logic [ADDR_W-1:0] vram_addr,
  input logic [14:0]       rom_addr,
  input logic [2:0]        rgb,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              blink
);

  assert_hsync_from_raster_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> $past(hsync_raw, 3));

  assert_dark_in_hsync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> rgb == 3'b000);

  assert_vsync_blanked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !$past(visible, 3));

  assert_load_two_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> ##2 load_stb);

  assert_fetch_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> (int'(vram_addr) < COLS * ROWS));

  assert_row_slot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rom_addr[4:0]) < GLYPH_H);

  assert_dark_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(visible, 3) |-> rgb == 3'b000);

  assert_blink_frame_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blink) |-> $past(frame_end));

endmodule

bind vga_text_engine vga_text_engine_chk #(
  .COLS(COLS), .ROWS(ROWS), .GLYPH_H(GLYPH_H), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .load_stb(load_stb),
  .visible(visible), .hsync_raw(hsync_raw), .frame_end(frame_end),
  .vram_addr(vram_addr), .rom_addr(rom_addr), .rgb(rgb),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .blink(blink)
);

// File: tb/vga_text_engine_test.sv
module vga_text_engine_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int cols, rows, gh, hfp, hs, hbp, vfp, vs, vbp, bf;
  } geom_t;

  localparam int RUN_CYCLES = 9984;  // twelve frames of the reduced geometry

  // Reduced-geometry instance
  logic [3:0]  s_vaddr;
  logic [15:0] s_vdata;
  logic [14:0] s_raddr;
  logic [7:0]  s_rdata;
  logic [2:0]  s_rgb;
  logic        s_hs, s_vs, s_blink;

  vga_text_engine #(
    .COLS(6), .ROWS(2), .GLYPH_H(4), .H_FP(4), .H_SYNC(8), .H_BP(4),
    .V_FP(1), .V_SYNC(2), .V_BP(2), .BLINK_FRAMES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .vram_addr(s_vaddr), .vram_data(s_vdata),
    .rom_addr(s_raddr), .rom_data(s_rdata), .rgb(s_rgb),
    .hsync_n(s_hs), .vsync_n(s_vs), .blink(s_blink)
  );

  // Default-geometry instance
  logic [10:0] f_vaddr;
  logic [15:0] f_vdata;
  logic [14:0] f_raddr;
  logic [7:0]  f_rdata;
  logic [2:0]  f_rgb;
  logic        f_hs, f_vs, f_blink;

  vga_text_engine uut_full (
    .clk(clk), .rst_n(rst_n), .vram_addr(f_vaddr), .vram_data(f_vdata),
    .rom_addr(f_raddr), .rom_data(f_rdata), .rgb(f_rgb),
    .hsync_n(f_hs), .vsync_n(f_vs), .blink(f_blink)
  );

  // Memory contents as hash functions
  function automatic logic [15:0] cell_word(int idx);
    logic [31:0] x;
    x = 32'(idx) * 32'd40503 + 32'd977;
    return x[15:0] ^ x[20:5];
  endfunction

  function automatic logic [7:0] rom_byte(logic [14:0] a);
    logic [31:0] x;
    x = {17'd0, a} * 32'd2654435761;
    return x[23:16] ^ x[7:0] ^ a[7:0];
  endfunction

  // Registered read ports of both memories
  always_ff @(posedge clk) begin
    s_vdata <= cell_word(int'(s_vaddr));
    s_rdata <= rom_byte(s_raddr);
    f_vdata <= cell_word(int'(f_vaddr));
    f_rdata <= rom_byte(f_raddr);
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic raster(geom_t g, int k, output int h, output int v, output int f);
    int ht, vt;
    ht = g.cols * 8 + g.hfp + g.hs + g.hbp;
    vt = g.rows * g.gh + g.vfp + g.vs + g.vbp;
    h = k % ht;
    v = (k / ht) % vt;
    f = k / (ht * vt);
  endtask

  task automatic check_inst(string nm, geom_t g, int k, logic [31:0] vaddr,
                            logic [14:0] raddr, logic [2:0] rgb, logic hs_n,
                            logic vs_n, logic bl);
    int h, v, f, hvis, vvis;
    logic [15:0] cw;
    logic        eb;
    logic [14:0] ea;
    logic [7:0]  gb;
    logic [2:0]  er;
    hvis = g.cols * 8;
    vvis = g.rows * g.gh;

    raster(g, k, h, v, f);
    check("R9", {nm, " blink"}, 32'(bl), 32'(((f / g.bf) % 2) == 1));
    if (h < hvis && v < vvis && h % 8 == 0)
      check("R4", {nm, " vram_addr"}, vaddr, 32'((v / g.gh) * g.cols + h / 8));

    if (k >= 1) begin
      raster(g, k - 1, h, v, f);
      if (h < hvis && v < vvis && h % 8 == 0) begin
        cw = cell_word((v / g.gh) * g.cols + h / 8);
        eb = ((f / g.bf) % 2) == 1;
        ea = {cw[8], cw[9] & eb, cw[7:0], 5'(v % g.gh)};
        if (cw[9]) check("R6", {nm, " rom_addr flash"}, 32'(raddr), 32'(ea));
        else       check("R5", {nm, " rom_addr"}, 32'(raddr), 32'(ea));
      end
    end

    if (k < 3) begin
      check("R3", {nm, " early rgb"}, 32'(rgb), 32'd0);
      check("R3", {nm, " early hsync"}, 32'(hs_n), 32'd1);
      check("R3", {nm, " early vsync"}, 32'(vs_n), 32'd1);
    end else begin
      raster(g, k - 3, h, v, f);
      if (h < hvis && v < vvis) begin
        cw = cell_word((v / g.gh) * g.cols + h / 8);
        eb = ((f / g.bf) % 2) == 1;
        ea = {cw[8], cw[9] & eb, cw[7:0], 5'(v % g.gh)};
        gb = rom_byte(ea);
        er = gb[7 - (h % 8)] ? cw[12:10] : cw[15:13];
        check("R7", {nm, " pixel"}, 32'(rgb), 32'(er));
      end else begin
        check("R8", {nm, " blank"}, 32'(rgb), 32'd0);
      end
      check("R1", {nm, " hsync"}, 32'(hs_n),
            32'(!(h >= hvis + g.hfp && h < hvis + g.hfp + g.hs)));
      check("R2", {nm, " vsync"}, 32'(vs_n),
            32'(!(v >= vvis + g.vfp && v < vvis + g.vfp + g.vs)));
    end
  endtask

  initial begin
    geom_t gs;
    geom_t gf;
    gs = '{cols: 6, rows: 2, gh: 4, hfp: 4, hs: 8, hbp: 4, vfp: 1, vs: 2, vbp: 2, bf: 2};
    gf = '{cols: 80, rows: 24, gh: 20, hfp: 16, hs: 96, hbp: 48, vfp: 10, vs: 2, vbp: 33, bf: 32};

    // Reset state (R3, R9)
    repeat (3) @(negedge clk);
    check("R3", "reset rgb small", 32'(s_rgb), 32'd0);
    check("R3", "reset syncs small", 32'({s_hs, s_vs}), 32'd3);
    check("R9", "reset blink small", 32'(s_blink), 32'd0);
    check("R3", "reset rgb full", 32'(f_rgb), 32'd0);
    check("R3", "reset syncs full", 32'({f_hs, f_vs}), 32'd3);
    check("R9", "reset blink full", 32'(f_blink), 32'd0);

    rst_n = 1'b1;
    for (int k = 0; k < RUN_CYCLES; k++) begin
      check_inst("small", gs, k, 32'(s_vaddr), s_raddr, s_rgb, s_hs, s_vs, s_blink);
      check_inst("full", gf, k, 32'(f_vaddr), f_raddr, f_rgb, f_hs, f_vs, f_blink);
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Watchdog
  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule